// File: doc/BRIEF.md
# Presettable Up/Down Counter with Binary and Decade Modes

This block is a four-bit synchronous counter with two counting ranges. In binary mode it runs over 0 to 15. In decade mode it runs over 0 to 9, giving one BCD digit. A direction input sets whether it counts up or down. The count advances by one on a rising clock edge, but only when the active-low enable (`carry_in_ni`) is low and the load request (`preset_i`) is low.

Raising `preset_i` copies the four `jam_i` bits into the count at once, without waiting for a clock edge. While the request stays high, the count keeps following `jam_i`. After it falls, the loaded value is held until the next enabled clock edge. `carry_out_no` is an active-low terminal-count flag. It is built combinationally from the current count, mode, direction and enable. Several counters therefore share one clock and form a multi-digit counter: each stage's `carry_out_no` drives the next stage's `carry_in_ni`. An active-low asynchronous reset clears the count.

Top module: `updn_cnt`

## Requirements
- R1: While `rst_ni` is low, `count_o` reads 0 at once, with no clock edge needed. Reset takes priority over load.
- R2: While `preset_i` is high, `count_o` equals `jam_i` (bit 0 is the LSB) at once and follows any change on `jam_i`, and clock edges leave it unchanged.
- R3: After `preset_i` falls, `count_o` keeps the loaded value until the next rising clock edge at which both `carry_in_ni` and `preset_i` are low.
- R4: A rising clock edge with `carry_in_ni` high leaves `count_o` unchanged.
- R5: With `bin_mode_i`=1 and `up_i`=1, each enabled edge adds one modulo 16 (15 goes to 0).
- R6: With `bin_mode_i`=1 and `up_i`=0, each enabled edge subtracts one modulo 16 (0 goes to 15).
- R7: With `bin_mode_i`=0 and `up_i`=1, each enabled edge adds one modulo 10 (9 goes to 0).
- R8: With `bin_mode_i`=0 and `up_i`=0, each enabled edge subtracts one modulo 10 (0 goes to 9).
- R9: In decade mode, a count of 10 to 15 goes to 0 on an enabled up edge and to 9 on an enabled down edge.
- R10: `carry_out_no` is low exactly when `carry_in_ni` is low and the count is at its terminal value: 15 (binary, up), 9 (decade, up) or 0 (either mode, down). Otherwise it is high.
- R11: Two counters on one clock, the lower stage's `carry_out_no` driving the upper stage's `carry_in_ni`, count as a two-digit counter. The upper stage advances only on edges where the lower stage is at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carry_in_ni | input | 1 | Count enable / cascade carry in, active low |
| bin_mode_i | input | 1 | 1 = binary (mod 16), 0 = decade (mod 10) |
| up_i | input | 1 | 1 = count up, 0 = count down |
| preset_i | input | 1 | Asynchronous load request, active high |
| jam_i | input | WIDTH | Load value |
| count_o | output | WIDTH | Current count |
| carry_out_no | output | 1 | Terminal-count carry out, active low |

## Verification
The bench drives the counter across every wrap boundary in both modes and both directions. A design that used the wrong modulus, or wrapped decade down to 15, would show a wrong value right after the edge. It loads decade mode with illegal values 10 to 15 and then counts in each direction. A design without a recovery path would stay stuck out of range or pass through 10 to 15. It changes `jam_i` while the load request is held, and checks the count between clock edges. This catches a load that only happens on a clock edge, and one that latches `jam_i` once and ignores later changes. It also checks the carry at the terminal value with the enable high and with the enable low. A two-digit chain then shows whether the carry arrives in the same clock period: a late carry would make the upper digit step one edge late.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  typedef enum logic {
    MODE_DEC = 1'b0,
    MODE_BIN = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cnt_step.sv
module cnt_step
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int DEC_MAX = 9
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             bin_mode_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] DmaxV = WIDTH'(DEC_MAX);
  localparam logic [WIDTH-1:0] OneV  = WIDTH'(1);

  cnt_mode_e mode;
  cnt_dir_e  dir;
  logic [WIDTH-1:0] inc_v, dec_v;

  assign mode  = cnt_mode_e'(bin_mode_i);
  assign dir   = cnt_dir_e'(up_i);
  assign inc_v = cnt_i + OneV;
  assign dec_v = cnt_i - OneV;

  always_comb begin
    unique case ({mode, dir})
      {MODE_BIN, DIR_UP}: cnt_o = inc_v;
      {MODE_BIN, DIR_DN}: cnt_o = dec_v;
      // out-of-range decade values recover to 0 (up) or DEC_MAX (down)
      {MODE_DEC, DIR_UP}: cnt_o = (cnt_i >= DmaxV) ? '0 : inc_v;
      default:            cnt_o = (cnt_i == '0 || cnt_i > DmaxV) ? DmaxV : dec_v;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int DEC_MAX = 9
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             bin_mode_i,
  input  logic             up_i,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] DmaxV = WIDTH'(DEC_MAX);
  localparam logic [WIDTH-1:0] BmaxV = '1;

  logic [WIDTH-1:0] top_v;

  assign top_v  = (cnt_mode_e'(bin_mode_i) == MODE_BIN) ? BmaxV : DmaxV;
  assign term_o = (cnt_dir_e'(up_i) == DIR_UP) ? (cnt_i == top_v) : (cnt_i == '0);
endmodule

// File: rtl/cnt_bit.sv
module cnt_bit (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/updn_cnt.sv
module updn_cnt #(
  parameter int WIDTH   = 4,
  parameter int DEC_MAX = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             carry_in_ni,
  input  logic             bin_mode_i,
  input  logic             up_i,
  input  logic             preset_i,
  input  logic [WIDTH-1:0] jam_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_out_no
);
  logic [WIDTH-1:0] cnt_q, cnt_nxt, cnt_d, clr_v, set_v;
  logic adv, at_term;

  assign adv   = ~carry_in_ni & ~preset_i;
  assign cnt_d = adv ? cnt_nxt : cnt_q;

  cnt_step #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_step (
    .cnt_i      (cnt_q),
    .bin_mode_i (bin_mode_i),
    .up_i       (up_i),
    .cnt_o      (cnt_nxt)
  );

  cnt_term #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_term (
    .cnt_i      (cnt_q),
    .bin_mode_i (bin_mode_i),
    .up_i       (up_i),
    .term_o     (at_term)
  );

  // per-bit async set/clear makes the load transparent to jam_i
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign clr_v[i] = ~rst_ni | (preset_i & ~jam_i[i]);
    assign set_v[i] = rst_ni & preset_i & jam_i[i];
    cnt_bit u_bit (
      .clk_i (clk_i),
      .clr_i (clr_v[i]),
      .set_i (set_v[i]),
      .d_i   (cnt_d[i]),
      .q_o   (cnt_q[i])
    );
  end

  assign count_o      = cnt_q;
  assign carry_out_no = ~(~carry_in_ni & at_term);
endmodule

// File: rtl/updn_cnt_chk.sv
module updn_cnt_chk #(
  parameter int WIDTH   = 4,
  parameter int DEC_MAX = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             carry_in_ni,
  input logic             bin_mode_i,
  input logic             up_i,
  input logic             preset_i,
  input logic [WIDTH-1:0] jam_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_out_no
);
  localparam logic [WIDTH-1:0] DmaxV = WIDTH'(DEC_MAX);

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |-> count_o == jam_i);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_in_ni && !preset_i) |=> (preset_i || $stable(count_o)));

  // R5
  bin_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_in_ni && !preset_i && bin_mode_i && up_i)
    |=> (preset_i || count_o == WIDTH'($past(count_o) + 1'b1)));

  // R7
  dec_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_in_ni && !preset_i && !bin_mode_i && up_i && count_o == DmaxV)
    |=> (preset_i || count_o == '0));

  // R8
  dec_wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_in_ni && !preset_i && !bin_mode_i && !up_i && count_o == '0)
    |=> (preset_i || count_o == DmaxV));

  // R10
  carry_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_in_ni |-> carry_out_no);
endmodule

bind updn_cnt updn_cnt_chk #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_chk (.*);

// File: tb/updn_cnt_tb.sv
module updn_cnt_tb;
  localparam int CLK_P = 10;

  typedef struct {
    int    v;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ci_n = 1'b1, bin = 1'b1, up = 1'b1, pre = 1'b0;
  logic [3:0] jam = '0;
  logic [3:0] cnt;
  logic co_n;

  logic ch_pre = 1'b0;
  logic [3:0] lo_cnt, hi_cnt;
  logic lo_co, hi_co;

  int n_chk = 0, n_fail = 0;
  int m = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  updn_cnt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .carry_in_ni(ci_n), .bin_mode_i(bin),
    .up_i(up), .preset_i(pre), .jam_i(jam), .count_o(cnt), .carry_out_no(co_n)
  );

  // R11 chain: decade digits, lower carry feeds upper enable
  updn_cnt u_lo (
    .clk_i(clk), .rst_ni(rst_n), .carry_in_ni(1'b0), .bin_mode_i(1'b0),
    .up_i(1'b1), .preset_i(ch_pre), .jam_i(4'd0), .count_o(lo_cnt), .carry_out_no(lo_co)
  );
  updn_cnt u_hi (
    .clk_i(clk), .rst_ni(rst_n), .carry_in_ni(lo_co), .bin_mode_i(1'b0),
    .up_i(1'b1), .preset_i(ch_pre), .jam_i(4'd0), .count_o(hi_cnt), .carry_out_no(hi_co)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(int v, bit b, bit u);
    if (b) return u ? (v + 1) % 16 : (v + 15) % 16;
    if (u) return (v >= 9) ? 0 : v + 1;
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  function automatic bit term(int v, bit b, bit u);
    if (!u) return v == 0;
    return b ? v == 15 : v == 9;
  endfunction

  // monitor: compare the count just after each edge against the queue
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, int'(cnt), it.v);
    end
  end

  task automatic step(bit c, bit b, bit u, string tag);
    item_t it;
    @(negedge clk);
    pre = 1'b0; ci_n = c; bin = b; up = u;
    #1;
    chk("R3 hold before edge", int'(cnt), m);
    chk("R10 carry", int'(co_n), (c ? 1 : int'(!term(m, b, u))));
    m = c ? m : nxt(m, b, u);
    it.v = m; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic load(int v);
    item_t it;
    @(negedge clk);
    pre = 1'b1; jam = 4'(v) ^ 4'hF;
    #1 chk("R2 async load", int'(cnt), v ^ 15);
    jam = 4'(v);
    #1 chk("R2 follows jam", int'(cnt), v);
    m = v;
    it.v = v; it.tag = "R2 edge ignored";
    sb.push_back(it);
  endtask

  initial begin
    #1 chk("R1 reset value", int'(cnt), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R5 binary up through 15 -> 0
    load(13);
    repeat (5) step(1'b0, 1'b1, 1'b1, "R5 bin up");
    // R4 enable high holds
    repeat (3) step(1'b1, 1'b1, 1'b1, "R4 hold");
    // R6 binary down through 0 -> 15
    repeat (3) step(1'b0, 1'b1, 1'b0, "R6 bin down");
    // R7 decade up through 9 -> 0
    load(7);
    repeat (4) step(1'b0, 1'b0, 1'b1, "R7 dec up");
    // R8 decade down through 0 -> 9
    repeat (3) step(1'b0, 1'b0, 1'b0, "R8 dec down");
    // R9 illegal recovery
    load(12);
    step(1'b0, 1'b0, 1'b1, "R9 illegal up");
    load(14);
    step(1'b0, 1'b0, 1'b0, "R9 illegal down");
    load(10);
    step(1'b0, 1'b0, 1'b0, "R9 illegal down from 10");
    // R10 terminal with enable high keeps carry high
    load(9);
    step(1'b1, 1'b0, 1'b1, "R10 gated terminal");
    step(1'b0, 1'b0, 1'b1, "R10 terminal up");
    // R1 async reset mid-run
    load(6);
    step(1'b1, 1'b1, 1'b1, "R4 hold");
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async reset", int'(cnt), 0);
    m = 0;
    @(negedge clk);
    rst_n = 1'b1;
    // R11 chain
    @(negedge clk);
    ch_pre = 1'b1;
    @(negedge clk);
    ch_pre = 1'b0;
    repeat (9) @(negedge clk);
    chk("R11 lo at 9", int'(lo_cnt), 9);
    chk("R11 hi before carry", int'(hi_cnt), 0);
    chk("R11 lo carry", int'(lo_co), 0);
    @(negedge clk);
    chk("R11 lo wrap", int'(lo_cnt), 0);
    chk("R11 hi step", int'(hi_cnt), 1);
    repeat (15) @(negedge clk);
    chk("R11 tens", int'(hi_cnt), 2);
    chk("R11 units", int'(lo_cnt), 5);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule